// File: doc/BRIEF.md
# I2C Stuck-SDA Bus Recovery Sequencer

This block frees an I2C bus that a slave has left holding SDA low after an interrupted transfer. On a trigger it takes ownership of both open-drain pins away from the normal transfer logic. It then clocks SCL in bursts of nine pulses and checks SDA after each burst. When SDA reads high, it creates a STOP condition and hands the pins back. If SDA never goes high, it stops after a bounded number of bursts and flags a timeout.

Pulse timing comes from a half-period count given in clock cycles. The system supplies the count that matches the bus rate, which is 5 us per half period at 100 kHz. The STOP low phase lasts two half periods, which is 10 us. SDA is sampled through a two-flop synchronizer, and the synchronized level is also brought out as a status bit. A `pin_force_o` output tells the pad mux to take its enables from this block. While it is high, `scl_low_o` and `sda_low_o` are the drive-low enables.

Top module: `i2c_bus_rescue`

## Requirements
- R1: After reset, `busy_o`, `pin_force_o`, `scl_low_o`, `sda_low_o`, `done_o` and `timeout_o` are all 0, and `sda_level_o` is 1.
- R2: A `start_i` pulse while idle sets `busy_o`, `pin_force_o` and `scl_low_o` on the next clock edge. `pin_force_o` equals `busy_o` at all times.
- R3: Each SCL pulse drives SCL low for N cycles and then releases it for N cycles, where N is `half_cnt_i` and a value of 0 acts as 1. A burst has 9 pulses. One extra released cycle follows each burst while SDA is sampled.
- R4: `sda_level_o` is `sda_i` delayed by two clock edges. The burst-end decision uses this synchronized level.
- R5: If the synchronized SDA is 0 at the end of a burst, the next burst starts immediately with SCL low.
- R6: If the synchronized SDA is 1 at the end of a burst, both lines stay released for N more cycles. SDA is then driven low for 2N cycles with SCL released. After that, both lines are released, and `done_o` pulses for one cycle in the cycle `busy_o` falls.
- R7: If SDA is still 0 after burst 1024, no STOP is generated. `timeout_o` pulses for one cycle in the cycle `busy_o` falls, and `done_o` stays 0.
- R8: `start_i` has no effect while `busy_o` is 1. The running sequence keeps its timing and no second sequence follows it.
- R9: `scl_low_o` and `sda_low_o` are never 1 at the same time, and neither is 1 unless `pin_force_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery trigger pulse |
| sda_i | input | 1 | Raw SDA pin level |
| half_cnt_i | input | CNT_W | SCL half period in clock cycles |
| pin_force_o | output | 1 | Pins owned by this block |
| scl_low_o | output | 1 | Drive SCL low |
| sda_low_o | output | 1 | Drive SDA low |
| sda_level_o | output | 1 | Synchronized SDA status |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse: STOP completed |
| timeout_o | output | 1 | One-cycle pulse: gave up after the burst limit |

## Verification
The bench rebuilds the pin waveform as a list of segments with their lengths and compares them against an expected list built from the requirements.
- Half periods of 1, 2 and 3 cycles are used. A design that miscounts its timer, loses the sample cycle, or miscounts pulses shifts a segment length.
- SDA is released in the first and in a later burst. A design that stops early or does an extra burst produces the wrong number of segments.
- A full run to the 1024-burst limit is included. A design with an off-by-one limit, or one that still sends a STOP on timeout, is caught at the tail of that list.
- A second trigger is fired mid-run. A design that restarts or queues a new sequence distorts or extends the list.

// File: rtl/rescue_pkg.sv
package rescue_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_SAMPLE,
    ST_BUS_REL,
    ST_STOP_LO
  } rescue_state_e;
endpackage

// File: rtl/rescue_sync.sv
module rescue_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // reset to 1: an idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rescue_timer.sv
module rescue_timer #(
  parameter int LEN_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             expire_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - LEN_W'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - LEN_W'(1);
  end

  assign expire_o = (cnt_q == '0);

  // R3: a phase may only end once its count has run out
  a_r3_no_early_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (len_i > LEN_W'(1)) |=> !expire_o);
endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue
  import rescue_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PULSES      = 9,
  parameter int MAX_BURSTS  = 1024,
  parameter int STOP_HALVES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sda_i,
  input  logic [CNT_W-1:0] half_cnt_i,
  output logic             pin_force_o,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic             sda_level_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o
);
  localparam int PW = $clog2(PULSES + 1);
  localparam int BW = $clog2(MAX_BURSTS + 1);
  localparam int LW = CNT_W + $clog2(STOP_HALVES + 1);

  rescue_state_e state_q, state_d;
  logic [PW-1:0] pulse_q;
  logic [BW-1:0] burst_q;
  logic          done_q, done_d, to_q, to_d;
  logic          sda_s, expire, load;
  logic [LW-1:0] half_len, len_d;

  rescue_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  assign half_len = (half_cnt_i == '0) ? LW'(1) : LW'(half_cnt_i);
  assign len_d    = (state_d == ST_STOP_LO) ? half_len * LW'(STOP_HALVES) : half_len;
  assign load     = (state_d != state_q);

  rescue_timer #(.LEN_W(LW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .len_i(len_d), .expire_o(expire)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    to_d    = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_CLK_LO;
      ST_CLK_LO:  if (expire) state_d = ST_CLK_HI;
      ST_CLK_HI:  if (expire) state_d = (pulse_q == PW'(PULSES - 1)) ? ST_SAMPLE : ST_CLK_LO;
      ST_SAMPLE: begin
        if (sda_s) state_d = ST_BUS_REL;
        else if (burst_q == BW'(MAX_BURSTS - 1)) begin
          state_d = ST_IDLE;
          to_d    = 1'b1;
        end else state_d = ST_CLK_LO;
      end
      ST_BUS_REL: if (expire) state_d = ST_STOP_LO;
      ST_STOP_LO: if (expire) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      burst_q <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      to_q    <= to_d;
      if (state_q == ST_IDLE) pulse_q <= '0;
      else if (state_q == ST_CLK_HI && expire)
        pulse_q <= (pulse_q == PW'(PULSES - 1)) ? '0 : pulse_q + PW'(1);
      if (state_q == ST_IDLE) burst_q <= '0;
      else if (state_q == ST_SAMPLE && !sda_s) burst_q <= burst_q + BW'(1);
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign pin_force_o = busy_o;
  assign scl_low_o   = (state_q == ST_CLK_LO);
  assign sda_low_o   = (state_q == ST_STOP_LO);
  assign sda_level_o = sda_s;
  assign done_o      = done_q;
  assign timeout_o   = to_q;

  a_r9_no_dual_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_low_o && sda_low_o));
  a_r9_drive_needs_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_low_o || sda_low_o) |-> pin_force_o);
  a_r2_start_pulls_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && scl_low_o));
  a_r8_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o || timeout_o));
  a_r6_done_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!busy_o && $past(sda_low_o)));
  a_r6_stop_scl_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> $past(pin_force_o && !scl_low_o));
  a_r7_timeout_no_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!busy_o && !done_o && !$past(sda_low_o)));
endmodule

// File: tb/sim_i2c_bus_rescue.sv
module sim_i2c_bus_rescue;
  localparam int CLK_PERIOD = 10;
  localparam int PULSES     = 9;
  localparam int MAXB       = 1024;

  typedef struct {
    int    kind;  // 0 released, 1 scl low, 2 sda low, 3 end (1=done, 2=timeout)
    int    len;
    string req;
  } ev_t;

  logic        clk_i = 0, rst_ni = 0, start_i = 0, sda_i = 1;
  logic [15:0] half_cnt_i = 16'd2;
  logic        pin_force_o, scl_low_o, sda_low_o, sda_level_o, busy_o, done_o, timeout_o;

  int   errors = 0, checks = 0;
  ev_t  exp_q[$];
  int   pulse_cnt = 0;
  bit   in_run = 0;
  int   seg_code = 0, seg_len = 0;
  bit   prev_scl = 0;
  int   r9_bad = 0, force_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  i2c_bus_rescue u0 (
    .clk_i, .rst_ni, .start_i, .sda_i, .half_cnt_i,
    .pin_force_o, .scl_low_o, .sda_low_o, .sda_level_o,
    .busy_o, .done_o, .timeout_o
  );

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic emit(int kind, int len);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(0, "R8 unexpected segment", kind * 1000000 + len, -1);
    end else begin
      e = exp_q.pop_front();
      check(kind == e.kind && len == e.len, e.req,
            kind * 1000000 + len, e.kind * 1000000 + e.len);
    end
  endtask

  // monitor: rebuild pin waveform into segments
  always @(negedge clk_i) begin
    if (rst_ni) begin
      int code;
      if (scl_low_o && sda_low_o) r9_bad++;
      if ((scl_low_o || sda_low_o) && !pin_force_o) r9_bad++;
      if (pin_force_o != busy_o) force_bad++;
      if (scl_low_o && !prev_scl) pulse_cnt++;
      prev_scl = scl_low_o;
      code = scl_low_o ? 1 : (sda_low_o ? 2 : 0);
      if (pin_force_o) begin
        if (in_run && code == seg_code) seg_len++;
        else begin
          if (in_run) emit(seg_code, seg_len);
          seg_code = code;
          seg_len  = 1;
          in_run   = 1;
        end
      end else if (in_run) begin
        emit(seg_code, seg_len);
        emit(3, int'(done_o) + 2 * int'(timeout_o));
        in_run = 0;
      end else if (done_o || timeout_o) begin
        emit(4, int'(done_o) + 2 * int'(timeout_o));
      end
    end
  end

  task automatic push(int kind, int len, string req);
    ev_t e;
    e.kind = kind; e.len = len; e.req = req;
    exp_q.push_back(e);
  endtask

  // rel_burst = 0 means SDA never releases
  task automatic run_case(int n, int rel_burst, bit retrig);
    int nb = (rel_burst == 0) ? MAXB : rel_burst;
    half_cnt_i = 16'(n);
    sda_i = 0;
    repeat (4) @(negedge clk_i);
    for (int b = 1; b <= nb; b++) begin
      for (int p = 1; p <= PULSES; p++) begin
        push(1, n, "R3 scl low phase");
        if (p < PULSES) push(0, n, "R3 scl high phase");
        else if (b < nb) push(0, n + 1, "R5 burst gap");
        else if (rel_burst != 0) push(0, 2 * n + 1, "R6 release before stop");
        else push(0, n + 1, "R7 last burst gap");
      end
    end
    if (rel_burst != 0) begin
      push(2, 2 * n, "R6 stop low phase");
      push(3, 1, "R6 done pulse");
    end else push(3, 2, "R7 timeout pulse");
    pulse_cnt = 0;
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    check(busy_o && scl_low_o && pin_force_o, "R2 start takes pins",
          {busy_o, scl_low_o, pin_force_o}, 3'b111);
    if (retrig) begin
      while (pulse_cnt < 3) @(negedge clk_i);
      start_i = 1;
      @(negedge clk_i);
      start_i = 0;
    end
    if (rel_burst != 0) begin
      while (pulse_cnt < PULSES * (rel_burst - 1) + 1) @(negedge clk_i);
      sda_i = 1;
    end
    while (busy_o) @(negedge clk_i);
    repeat (20) @(negedge clk_i);
    check(exp_q.size() == 0 && !busy_o, "R8 no leftover or restart",
          exp_q.size(), 0);
    exp_q.delete();
    sda_i = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!busy_o && !pin_force_o && !scl_low_o && !sda_low_o && !done_o && !timeout_o,
          "R1 reset outputs", {busy_o, pin_force_o, scl_low_o, sda_low_o, done_o, timeout_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(sda_level_o == 1'b1, "R1 sda level after reset", sda_level_o, 1);
    // R4 synchronizer latency
    sda_i = 0;
    @(negedge clk_i);
    check(sda_level_o == 1'b1, "R4 sync first edge", sda_level_o, 1);
    @(negedge clk_i);
    check(sda_level_o == 1'b0, "R4 sync second edge", sda_level_o, 0);
    sda_i = 1;
    repeat (3) @(negedge clk_i);
    check(sda_level_o == 1'b1, "R4 sync follows high", sda_level_o, 1);

    run_case(3, 1, 0);   // R6 release in first burst
    run_case(2, 3, 1);   // R5 several bursts, R8 retrigger mid-run
    run_case(1, 2, 0);   // R3 minimum half period
    run_case(2, 0, 0);   // R7 full timeout

    check(r9_bad == 0, "R9 pin drive rules", r9_bad, 0);
    check(force_bad == 0, "R2 force equals busy", force_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule